// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts activity inside an accelerator. It holds a bank of 32-bit event counters and one 48-bit cycle counter. Each event counter has a type register that picks one of the accelerator's event lines, and the counter adds one on every clock in which that line is high. The cycle counter adds one on every clock while it is running. Its running state can be armed by a selectable start event and halted by a selectable stop event, so software can measure the time between two points of interest.

Software reaches everything through a simple word-addressed register port. A write happens in the clock where `we_i` is high. Reads are combinational from `addr_i`. Counter enables, overflow flags and interrupt enables are each held as one mask with a write-one-to-set address and a write-one-to-clear address. When a counter wraps to zero, its overflow flag is set. The single interrupt output is raised while any flag is set whose interrupt enable is also set.

Word addresses: 0 control, 1/2 enable set/clear, 3/4 overflow set/clear, 5/6 interrupt-enable set/clear, 8/9 cycle counter low/high word, 10 cycle gating configuration, 16+i event counter i, 24+i event type i. All other addresses read 0 and ignore writes.

Top module: `perf_mon_unit`

## Requirements
- R1: The control register (address 0) holds the global count enable in bit 0, which reads back. Writing bit 1 as 1 zeroes the cycle counter, and writing bit 2 as 1 zeroes every event counter. Bits 1 and 2 are not stored and read as 0.
- R2: The enable mask uses bits 3:0 for event counters 0..3 and bit 31 for the cycle counter. Writing ones to address 1 sets those bits and writing ones to address 2 clears them. Both addresses read the current mask, and the other bits read 0. A counter whose enable bit is clear does not count.
- R3: Event counter i (address 16+i) adds one in each clock in which the global enable is set, its enable bit is set, and its selected event line is high.
- R4: The 48-bit cycle counter reads and writes bits 31:0 at address 8 and bits 47:32 at address 9, in data bits 15:0. It counts only while the global enable and mask bit 31 are both set.
- R5: The gating register (address 10) holds a start event number in bits 9:0 and a stop event number in bits 25:16. With start 0 the counter is always allowed to run. Otherwise a start pulse arms it from the next clock, and a stop pulse (when stop is not 0) halts it after the current clock. Stop wins over start in the same clock.
- R6: In one clock, a register write of a counter value wins over a reset bit from the control register, and the reset bit wins over an increment.
- R7: A counter that increments from all ones to zero sets its overflow flag, which stays set. Address 3 reads the flags and sets the flags at the bits written as 1. Address 4 clears the flags at the bits written as 1, but a wrap in the same clock still sets its flag.
- R8: Addresses 5/6 set/clear the interrupt-enable mask, and both read it. `irq_o` is high exactly while some bit is set in both the flags and the interrupt-enable mask.
- R9: After reset all counters, masks, flags, types and gating fields are 0, and `irq_o` is low.
- R10: Event type i (address 24+i) holds a 10-bit event number. Value n in 1..8 selects `evt_i[n-1]`. Value 0, and any value above 8, selects no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | Event lines from the accelerator, one pulse per clock counted |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i (combinational) |
| irq_o | output | 1 | Counter overflow interrupt |

## Verification
Two functions can fall in the same clock: a software write to a counter or to the overflow-clear address, and an increment or wrap of that same counter from an event or the running cycle counter. The bench provokes these collisions on purpose. It loads a counter while its event line is high. It writes all ones to a counter and then acknowledges the flag in the clock where the counter wraps. The random phase loads counters with values close to all ones while events toggle, so such collisions happen often. Each outcome is judged against a bench model that applies the priority order of R6 and R7 and then compares every readback and the interrupt line.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_CTRL     = 6'd0;
  localparam logic [ADDR_W-1:0] A_EN_SET   = 6'd1;
  localparam logic [ADDR_W-1:0] A_EN_CLR   = 6'd2;
  localparam logic [ADDR_W-1:0] A_OVF_SET  = 6'd3;
  localparam logic [ADDR_W-1:0] A_OVF_CLR  = 6'd4;
  localparam logic [ADDR_W-1:0] A_IRQ_SET  = 6'd5;
  localparam logic [ADDR_W-1:0] A_IRQ_CLR  = 6'd6;
  localparam logic [ADDR_W-1:0] A_CYC_LO   = 6'd8;
  localparam logic [ADDR_W-1:0] A_CYC_HI   = 6'd9;
  localparam logic [ADDR_W-1:0] A_CYC_CFG  = 6'd10;
  localparam logic [ADDR_W-1:0] A_CNT_BASE = 6'd16;
  localparam logic [ADDR_W-1:0] A_TYP_BASE = 6'd24;

  // control register bit positions
  localparam int CTRL_EN_BIT     = 0;
  localparam int CTRL_CYC_RST    = 1;
  localparam int CTRL_EVT_RST    = 2;
  // gating register field offsets
  localparam int CFG_START_LSB   = 0;
  localparam int CFG_STOP_LSB    = 16;
endpackage

// File: rtl/pmu_evt_sel.sv
module pmu_evt_sel #(
  parameter int NUM_EVENTS = 8,
  parameter int ID_W       = 10
) (
  input  logic [NUM_EVENTS-1:0] evt_i,
  input  logic [ID_W-1:0]       id_i,
  output logic                  hit_o
);
  // id 0 and ids beyond NUM_EVENTS select nothing
  always_comb begin
    hit_o = 1'b0;
    for (int k = 0; k < NUM_EVENTS; k++) begin
      if (id_i == ID_W'(k + 1)) hit_o = hit_o | evt_i[k];
    end
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = inc_i & ~ld_i & ~clr_i & (&cnt_q);
endmodule

// File: rtl/pmu_cyc_gate.sv
module pmu_cyc_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_used_i,
  input  logic start_hit_i,
  input  logic stop_hit_i,
  output logic gate_o
);
  logic run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= 1'b0;
    else if (stop_hit_i)  run_q <= 1'b0;
    else if (start_hit_i) run_q <= 1'b1;
  end

  // no start event configured: always allowed to run
  assign gate_o = ~start_used_i | run_q;
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import perf_mon_pkg::*;
#(
  parameter int NUM_EVT_CNT  = 4,
  parameter int NUM_EVENTS   = 8,
  parameter int CYC_W        = 48,
  parameter int EVT_ID_W     = 10,
  parameter int CYC_MASK_BIT = 31
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_EVENTS-1:0] evt_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  irq_o
);
  localparam int CYC_HI_W = CYC_W - DATA_W;
  localparam logic [DATA_W-1:0] EVT_MASK  = DATA_W'((64'd1 << NUM_EVT_CNT) - 64'd1);
  localparam logic [DATA_W-1:0] CYC_MASK  = DATA_W'(64'd1 << CYC_MASK_BIT);
  localparam logic [DATA_W-1:0] VLD_MASK  = EVT_MASK | CYC_MASK;

  logic                glob_en_q;
  logic [DATA_W-1:0]   en_q, ovf_q, irq_en_q;
  logic [EVT_ID_W-1:0] start_q, stop_q;
  logic [EVT_ID_W-1:0] typ_q [NUM_EVT_CNT];

  logic wr_ctrl, wr_en_set, wr_en_clr, wr_ovf_set, wr_ovf_clr;
  logic wr_irq_set, wr_irq_clr, wr_cyc_lo, wr_cyc_hi, wr_cfg;
  logic cyc_rst, evt_rst;

  assign wr_ctrl    = we_i && (addr_i == A_CTRL);
  assign wr_en_set  = we_i && (addr_i == A_EN_SET);
  assign wr_en_clr  = we_i && (addr_i == A_EN_CLR);
  assign wr_ovf_set = we_i && (addr_i == A_OVF_SET);
  assign wr_ovf_clr = we_i && (addr_i == A_OVF_CLR);
  assign wr_irq_set = we_i && (addr_i == A_IRQ_SET);
  assign wr_irq_clr = we_i && (addr_i == A_IRQ_CLR);
  assign wr_cyc_lo  = we_i && (addr_i == A_CYC_LO);
  assign wr_cyc_hi  = we_i && (addr_i == A_CYC_HI);
  assign wr_cfg     = we_i && (addr_i == A_CYC_CFG);
  assign cyc_rst    = wr_ctrl & wdata_i[CTRL_CYC_RST];
  assign evt_rst    = wr_ctrl & wdata_i[CTRL_EVT_RST];

  // ---------------- cycle counter ----------------
  logic [CYC_W-1:0] cyc_cnt, cyc_ld_val;
  logic             cyc_wrap, cyc_gate, start_hit, stop_hit, cyc_inc;

  pmu_evt_sel #(.NUM_EVENTS(NUM_EVENTS), .ID_W(EVT_ID_W)) u_start_sel (
    .evt_i(evt_i), .id_i(start_q), .hit_o(start_hit)
  );
  pmu_evt_sel #(.NUM_EVENTS(NUM_EVENTS), .ID_W(EVT_ID_W)) u_stop_sel (
    .evt_i(evt_i), .id_i(stop_q), .hit_o(stop_hit)
  );
  pmu_cyc_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_used_i(start_q != '0),
    .start_hit_i (start_hit),
    .stop_hit_i  (stop_hit),
    .gate_o      (cyc_gate)
  );

  assign cyc_inc    = glob_en_q & en_q[CYC_MASK_BIT] & cyc_gate;
  assign cyc_ld_val = wr_cyc_lo ? {cyc_cnt[CYC_W-1:DATA_W], wdata_i}
                                : {wdata_i[CYC_HI_W-1:0], cyc_cnt[DATA_W-1:0]};

  pmu_counter #(.W(CYC_W)) u_cyc_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (wr_cyc_lo | wr_cyc_hi),
    .ld_val_i(cyc_ld_val),
    .clr_i   (cyc_rst),
    .inc_i   (cyc_inc),
    .cnt_o   (cyc_cnt),
    .wrap_o  (cyc_wrap)
  );

  // ---------------- event counters ----------------
  logic [DATA_W-1:0]             evt_cnt [NUM_EVT_CNT];
  logic [NUM_EVT_CNT-1:0]        evt_wrap;
  logic [NUM_EVT_CNT*DATA_W-1:0] evt_cnt_flat;

  for (genvar i = 0; i < NUM_EVT_CNT; i++) begin : g_evt
    logic hit, wr_cnt, wr_typ;
    assign wr_cnt = we_i && (addr_i == A_CNT_BASE + ADDR_W'(i));
    assign wr_typ = we_i && (addr_i == A_TYP_BASE + ADDR_W'(i));

    pmu_evt_sel #(.NUM_EVENTS(NUM_EVENTS), .ID_W(EVT_ID_W)) u_sel (
      .evt_i(evt_i), .id_i(typ_q[i]), .hit_o(hit)
    );

    pmu_counter #(.W(DATA_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ld_i    (wr_cnt),
      .ld_val_i(wdata_i),
      .clr_i   (evt_rst),
      .inc_i   (glob_en_q & en_q[i] & hit),
      .cnt_o   (evt_cnt[i]),
      .wrap_o  (evt_wrap[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     typ_q[i] <= '0;
      else if (wr_typ) typ_q[i] <= wdata_i[EVT_ID_W-1:0];
    end

    assign evt_cnt_flat[i*DATA_W +: DATA_W] = evt_cnt[i];
  end

  // ---------------- control and masks ----------------
  logic [DATA_W-1:0] wrap_vec;

  always_comb begin
    wrap_vec = '0;
    wrap_vec[CYC_MASK_BIT] = cyc_wrap;
    for (int i = 0; i < NUM_EVT_CNT; i++) wrap_vec[i] = evt_wrap[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glob_en_q <= 1'b0;
      en_q      <= '0;
      irq_en_q  <= '0;
      ovf_q     <= '0;
      start_q   <= '0;
      stop_q    <= '0;
    end else begin
      if (wr_ctrl)    glob_en_q <= wdata_i[CTRL_EN_BIT];
      if (wr_en_set)  en_q      <= en_q | (wdata_i & VLD_MASK);
      if (wr_en_clr)  en_q      <= en_q & ~wdata_i;
      if (wr_irq_set) irq_en_q  <= irq_en_q | (wdata_i & VLD_MASK);
      if (wr_irq_clr) irq_en_q  <= irq_en_q & ~wdata_i;
      // hardware wrap wins over software acknowledge
      ovf_q <= ((ovf_q & ~(wr_ovf_clr ? wdata_i : '0))
               | (wr_ovf_set ? wdata_i : '0) | wrap_vec) & VLD_MASK;
      if (wr_cfg) begin
        start_q <= wdata_i[CFG_START_LSB +: EVT_ID_W];
        stop_q  <= wdata_i[CFG_STOP_LSB +: EVT_ID_W];
      end
    end
  end

  assign irq_o = |(ovf_q & irq_en_q);

  // ---------------- read mux ----------------
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:                 rdata_o[CTRL_EN_BIT] = glob_en_q;
      A_EN_SET,  A_EN_CLR:    rdata_o = en_q;
      A_OVF_SET, A_OVF_CLR:   rdata_o = ovf_q;
      A_IRQ_SET, A_IRQ_CLR:   rdata_o = irq_en_q;
      A_CYC_LO:               rdata_o = cyc_cnt[DATA_W-1:0];
      A_CYC_HI:               rdata_o[CYC_HI_W-1:0] = cyc_cnt[CYC_W-1:DATA_W];
      A_CYC_CFG: begin
        rdata_o[CFG_START_LSB +: EVT_ID_W] = start_q;
        rdata_o[CFG_STOP_LSB +: EVT_ID_W]  = stop_q;
      end
      default: ;
    endcase
    for (int i = 0; i < NUM_EVT_CNT; i++) begin
      if (addr_i == A_CNT_BASE + ADDR_W'(i)) rdata_o = evt_cnt[i];
      if (addr_i == A_TYP_BASE + ADDR_W'(i)) rdata_o = DATA_W'(typ_q[i]);
    end
  end
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
  import perf_mon_pkg::*;
#(
  parameter int NUM_EVT_CNT = 4,
  parameter int CYC_W       = 48
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          we_i,
  input logic [ADDR_W-1:0]             addr_i,
  input logic [DATA_W-1:0]             wdata_i,
  input logic                          irq_o,
  input logic                          glob_en_q,
  input logic [CYC_W-1:0]              cyc_cnt,
  input logic [NUM_EVT_CNT*DATA_W-1:0] evt_cnt_flat,
  input logic [DATA_W-1:0]             ovf_q
);
  // R3: event counters hold while globally disabled and untouched by software
  p_evt_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glob_en_q && !we_i) |=> $stable(evt_cnt_flat));

  // R4: cycle counter holds while globally disabled and untouched by software
  p_cyc_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glob_en_q && !we_i) |=> $stable(cyc_cnt));

  // R6: a value write lands regardless of a same-clock increment
  p_write_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CNT_BASE) |=> (evt_cnt_flat[DATA_W-1:0] == $past(wdata_i)));

  // R7: without a register write no overflow flag falls
  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

  // R8: clearing every interrupt enable silences the output
  p_irq_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_IRQ_CLR && wdata_i == '1) |=> !irq_o);
endmodule

bind perf_mon_unit pmu_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .irq_o       (irq_o),
  .glob_en_q   (glob_en_q),
  .cyc_cnt     (cyc_cnt),
  .evt_cnt_flat(evt_cnt_flat),
  .ovf_q       (ovf_q)
);

// File: tb/perf_mon_unit_bench.sv
module perf_mon_unit_bench;
  localparam int NC = 4;
  localparam int NEV = 8;
  localparam bit [31:0] VM = 32'h8000_000F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt = '0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string phase_tag = "";

  always #4 clk = ~clk;

  perf_mon_unit u_perf_mon_unit (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // ---------------- model state ----------------
  bit        m_glob, m_run;
  bit [31:0] m_en, m_ovf, m_irqen;
  bit [47:0] m_cyc;
  bit [9:0]  m_start, m_stop;
  bit [31:0] m_cnt [NC];
  bit [9:0]  m_typ [NC];

  function automatic bit ev_hit(bit [9:0] id, bit [7:0] e);
    if (id >= 1 && id <= NEV) return e[id-1];
    return 1'b0;
  endfunction

  function automatic bit [31:0] read_exp(bit [5:0] a);
    if (a >= 16 && a < 16 + NC) return m_cnt[a-16];
    if (a >= 24 && a < 24 + NC) return {22'b0, m_typ[a-24]};
    case (a)
      0: return {31'b0, m_glob};
      1, 2: return m_en;
      3, 4: return m_ovf;
      5, 6: return m_irqen;
      8: return m_cyc[31:0];
      9: return {16'b0, m_cyc[47:32]};
      10: return {6'b0, m_stop, 6'b0, m_start};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(bit [5:0] a);
    if (phase_tag != "") return phase_tag;
    if (a >= 16 && a < 20) return "R3";
    if (a >= 24 && a < 28) return "R10";
    case (a)
      0: return "R1";
      1, 2: return "R2";
      3, 4: return "R7";
      5, 6: return "R8";
      8, 9: return "R4";
      10: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic model_step();
    bit        n_glob, n_run, cinc, hit;
    bit [31:0] n_en, n_ovf, n_irqen, wrap;
    bit [47:0] n_cyc;
    bit [9:0]  n_start, n_stop;
    bit [31:0] n_cnt [NC];
    bit [9:0]  n_typ [NC];
    n_glob = m_glob; n_en = m_en; n_irqen = m_irqen; n_cyc = m_cyc;
    n_start = m_start; n_stop = m_stop; n_run = m_run; wrap = '0;
    for (int i = 0; i < NC; i++) begin n_cnt[i] = m_cnt[i]; n_typ[i] = m_typ[i]; end
    // R5 gating
    if (ev_hit(m_stop, evt)) n_run = 1'b0;
    else if (ev_hit(m_start, evt)) n_run = 1'b1;
    // R4 / R6 cycle counter
    cinc = m_glob && m_en[31] && (m_start == 0 || m_run);
    if (we && addr == 8) n_cyc = {m_cyc[47:32], wdata};
    else if (we && addr == 9) n_cyc = {wdata[15:0], m_cyc[31:0]};
    else if (we && addr == 0 && wdata[1]) n_cyc = '0;
    else if (cinc) begin
      if (m_cyc == 48'hFFFF_FFFF_FFFF) wrap[31] = 1'b1;
      n_cyc = m_cyc + 48'd1;
    end
    // R3 / R6 event counters
    for (int i = 0; i < NC; i++) begin
      hit = m_glob && m_en[i] && ev_hit(m_typ[i], evt);
      if (we && addr == 6'(16 + i)) n_cnt[i] = wdata;
      else if (we && addr == 0 && wdata[2]) n_cnt[i] = '0;
      else if (hit) begin
        if (m_cnt[i] == 32'hFFFF_FFFF) wrap[i] = 1'b1;
        n_cnt[i] = m_cnt[i] + 32'd1;
      end
      if (we && addr == 6'(24 + i)) n_typ[i] = wdata[9:0];
    end
    // R7 flags
    n_ovf = ((m_ovf & ~((we && addr == 4) ? wdata : 32'h0))
            | ((we && addr == 3) ? wdata : 32'h0) | wrap) & VM;
    if (we && addr == 0) n_glob = wdata[0];
    if (we && addr == 1) n_en = m_en | (wdata & VM);
    if (we && addr == 2) n_en = m_en & ~wdata;
    if (we && addr == 5) n_irqen = m_irqen | (wdata & VM);
    if (we && addr == 6) n_irqen = m_irqen & ~wdata;
    if (we && addr == 10) begin n_start = wdata[9:0]; n_stop = wdata[25:16]; end
    m_glob = n_glob; m_en = n_en; m_ovf = n_ovf; m_irqen = n_irqen; m_cyc = n_cyc;
    m_start = n_start; m_stop = n_stop; m_run = n_run;
    for (int i = 0; i < NC; i++) begin m_cnt[i] = n_cnt[i]; m_typ[i] = n_typ[i]; end
  endtask

  task automatic chk(bit [31:0] act, bit [31:0] exp, string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h t=%0t", tag, addr, act, exp, $time);
    end
  endtask

  // one clock: drive, compare readback and interrupt, advance the model
  task automatic cyc(bit w, bit [5:0] a, bit [31:0] d, bit [7:0] e);
    @(negedge clk);
    we = w; addr = a; wdata = d; evt = e;
    #1;
    chk(rdata, read_exp(a), req_of(a));
    chk({31'b0, irq}, {31'b0, |(m_ovf & m_irqen)}, (phase_tag != "") ? phase_tag : "R8");
    model_step();
  endtask

  task automatic rd(bit [5:0] a);
    cyc(1'b0, a, 32'h0, 8'h0);
  endtask

  task automatic wr(bit [5:0] a, bit [31:0] d);
    cyc(1'b1, a, d, 8'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: every address reads its reset value
    phase_tag = "R9";
    for (int a = 0; a < 32; a++) rd(6'(a));
    phase_tag = "";

    // R1 / R2 / R10 setup
    wr(0, 32'h1);
    rd(0);
    wr(1, 32'hFFFF_FFFF);
    rd(1);
    for (int i = 0; i < NC; i++) wr(6'(24 + i), 32'(i + 1));
    wr(5, 32'hFFFF_FFFF);

    // R3: event patterns
    cyc(0, 16, 0, 8'h0F);
    cyc(0, 17, 0, 8'h05);
    cyc(0, 18, 0, 8'h0A);
    for (int i = 0; i < NC; i++) rd(6'(16 + i));

    // R10: type beyond the event range never counts
    wr(24, 32'd9);
    cyc(0, 16, 0, 8'hFF);
    cyc(0, 16, 0, 8'hFF);
    rd(16);
    wr(24, 32'd1);

    // R6: load wins over increment, reset wins over increment
    phase_tag = "R6";
    cyc(1, 16, 32'h1234, 8'h01);
    rd(16);
    cyc(1, 0, 32'h5, 8'h0F);
    for (int i = 0; i < NC; i++) rd(6'(16 + i));
    phase_tag = "";

    // R7 / R8: wrap raises flag and interrupt
    wr(17, 32'hFFFF_FFFF);
    cyc(0, 3, 0, 8'h02);
    rd(3);
    wr(4, 32'h2);
    rd(3);
    // clear and wrap in the same clock: wrap wins
    phase_tag = "R7";
    wr(17, 32'hFFFF_FFFF);
    cyc(1, 4, 32'h2, 8'h02);
    rd(3);
    wr(6, 32'hFFFF_FFFF);
    rd(5);
    wr(4, 32'hFFFF_FFFF);
    phase_tag = "";

    // R4: cycle counter wrap via both halves
    wr(8, 32'hFFFF_FFFD);
    wr(9, 32'h0000_FFFF);
    rd(9);
    rd(8);
    rd(8);
    rd(3);

    // R5: start on event 3, stop on event 4
    phase_tag = "R5";
    wr(10, {6'b0, 10'd4, 6'b0, 10'd3});
    wr(8, 32'h0);
    rd(8);
    rd(8);
    cyc(0, 8, 0, 8'h04);
    rd(8);
    rd(8);
    cyc(0, 8, 0, 8'h08);
    rd(8);
    rd(8);
    cyc(0, 8, 0, 8'h0C);
    rd(8);
    phase_tag = "";

    // R2: disabling counter 0 stops it
    wr(2, 32'h1);
    rd(1);
    cyc(0, 16, 0, 8'h01);
    rd(16);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      bit [5:0]  a;
      bit [31:0] d;
      bit        w;
      int        sel;
      sel = $urandom % 10;
      case (sel)
        0: a = 6'($urandom % 11);
        1, 2, 3: a = 6'(16 + $urandom % NC);
        4: a = 6'(24 + $urandom % NC);
        5: a = 6'(8 + $urandom % 3);
        default: a = 6'($urandom % 64);
      endcase
      d = $urandom;
      if (a == 0) d = {29'b0, ($urandom % 8 == 0) ? 2'($urandom) : 2'b0, 1'b1};
      else if (a >= 24 && a < 28) d = 32'($urandom % 11);
      else if (a == 10) d = {6'b0, 10'($urandom % 11), 6'b0, 10'($urandom % 11)};
      else if ((a >= 16 && a < 20) || a == 8 || a == 9)
        if ($urandom % 3 == 0) d = 32'hFFFF_FFFF - ($urandom % 4);
      w = ($urandom % 3 == 0);
      cyc(w, a, d, 8'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule